// File: doc/BRIEF.md
# Paged One-Time-Programmable Memory Register Controller

This block sits on a simple register bus in front of a page-organised storage array of 512 pages, each 128 bits wide. Software reaches it through eight registers: a control register, a byte-enable register, a status register, a timing register and four 32-bit data words. The array is modelled as ordinary rewritable storage.

A page is transferred by a single write to the control register. That write names the page and can ask for a page write, a page read, or both. A page write goes from the data words into the page. A page read goes from the page into the data words. When both are asked for, the write is done first. Every transfer is filtered byte by byte through the 16-bit byte-enable register, and bytes that are not enabled keep their old contents at the destination.

Each control write raises a done flag in status, and software clears that flag by writing a 1 to it. Each register accepts only its own access width. Any other access is refused with an error code and leaves all state untouched.

Top module: `pgmem_ctrl`

## Requirements
- R1: After reset the registers read as follows: byte-enable 0xFFFF, timing 0x00001485, control 0, status 0, and all four data words 0.
- R2: The register offsets are fixed. The 16-bit registers are control at 0x00, byte-enable at 0x04 and status at 0x08. The 32-bit registers are timing at 0x0C and data words 0 to 3 at 0x80, 0x84, 0x88 and 0x8C. A read of a 16-bit register returns zero in bits 31:16.
- R3: The size code is 1 for 16 bits and 2 for 32 bits. Any other size code gives error code 1, whatever the offset; this check comes before the offset check. An offset that holds no register gives code 2. A width that does not match the register gives code 3. A refused access changes no state and returns read data 0. Error code 0 means the access was accepted.
- R4: A control write stores the written value ANDed with 0x39FF. Bits 8:0 of the written value select the page, bit 11 requests a page write and bit 12 requests a page read.
- R5: On a page write, byte i of the page (bits 8i+7:8i) is replaced only when byte-enable bit i is 1. The source image is data word 0 in bytes 0-3, zero in bytes 4-7, data word 1 in bytes 8-11 and zero in bytes 12-15.
- R6: On a page read, page byte i is copied into data byte i only when byte-enable bit i is 1. Data word k holds bytes 4k to 4k+3. Disabled bytes keep their contents.
- R7: When bits 11 and 12 are both set, the page write is applied first and the read then returns the updated page.
- R8: Every accepted control write sets status bit 0, whether or not a transfer is requested. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: Byte-enable, timing and the data words store any written value in full.
- R10: The results of a page transfer can be read in the cycle right after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_size | input | 2 | Access size code (1 = 16 bit, 2 = 32 bit) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| bus_err | output | 2 | Error code for the current access (0 = accepted) |

## Verification
The bench builds the block with its default parameters: 512 pages, an 8-bit offset and the 0x39FF control mask. This makes both the last page, 511, and the all-ones control write (which requests a transfer on page 511) reachable. Random traffic is kept to a small pool of pages spread across the page range. The pool includes both page 255 and page 256, so a mistake in the page-index bits shows up as a data mismatch. Byte-enable values are drawn at random and also forced to all-ones and all-zeros. This covers partial merges, combined write-then-read transfers, and reads of data words in the cycle right after the transfer.

// File: rtl/pgmem_pkg.sv
package pgmem_pkg;

  localparam int unsigned PAGE_BYTES = 16;
  localparam int unsigned PAGE_BITS  = PAGE_BYTES * 8;

  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {
    ACC_OK       = 2'd0,
    ACC_BAD_SIZE = 2'd1,
    ACC_NO_REG   = 2'd2,
    ACC_BAD_WID  = 2'd3
  } acc_err_e;

  typedef struct packed {
    logic       ctrl;
    logic       ben;
    logic       stat;
    logic       tim;
    logic [3:0] data;
  } reg_sel_t;

  // Copy each enabled byte of src over dst.
  function automatic logic [PAGE_BITS-1:0] byte_merge(
      input logic [PAGE_BITS-1:0]  dst,
      input logic [PAGE_BITS-1:0]  src,
      input logic [PAGE_BYTES-1:0] en);
    logic [PAGE_BITS-1:0] r;
    r = dst;
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (en[i]) r[8*i +: 8] = src[8*i +: 8];
    end
    return r;
  endfunction

  // Page image formed from the data words for a page write.
  function automatic logic [PAGE_BITS-1:0] write_image(
      input logic [31:0] w0,
      input logic [31:0] w1);
    return {32'h0, w1, 32'h0, w0};
  endfunction

endpackage

// File: rtl/pgmem_decode.sv
module pgmem_decode
  import pgmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output reg_sel_t          sel,
  output acc_err_e          err
);

  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_BEN  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_TIM  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(8'h80);

  reg_sel_t hit;
  logic     is_half, is_word, size_ok;

  always_comb begin
    hit      = '0;
    hit.ctrl = (addr == OFF_CTRL);
    hit.ben  = (addr == OFF_BEN);
    hit.stat = (addr == OFF_STAT);
    hit.tim  = (addr == OFF_TIM);
    for (int k = 0; k < 4; k++) begin
      hit.data[k] = (addr == OFF_DATA + ADDR_W'(4 * k));
    end
  end

  assign is_half = hit.ctrl | hit.ben | hit.stat;
  assign is_word = hit.tim  | (|hit.data);
  assign size_ok = (size == SZ_HALF) | (size == SZ_WORD);

  always_comb begin
    sel = '0;
    err = ACC_OK;
    if (valid) begin
      if (!size_ok) begin
        err = ACC_BAD_SIZE;
      end else if (!(is_half | is_word)) begin
        err = ACC_NO_REG;
      end else if ((is_half && size != SZ_HALF) || (is_word && size != SZ_WORD)) begin
        err = ACC_BAD_WID;
      end else begin
        sel = hit;
      end
    end
  end

endmodule

// File: rtl/pgmem_array.sv
module pgmem_array
  import pgmem_pkg::*;
#(
  parameter int unsigned PAGES   = 512,
  parameter int unsigned PAGE_AW = $clog2(PAGES)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [PAGE_AW-1:0]   page,
  input  logic [PAGE_BITS-1:0] wr_val,
  output logic [PAGE_BITS-1:0] rd_val
);

  logic [PAGE_BITS-1:0] store [PAGES];

  always_ff @(posedge clk) begin
    if (wr_en) store[page] <= wr_val;
  end

  assign rd_val = store[page];

endmodule

// File: rtl/pgmem_regfile.sv
module pgmem_regfile
  import pgmem_pkg::*;
#(
  parameter logic [15:0] CTRL_MASK = 16'h39FF,
  parameter logic [15:0] BEN_RST   = 16'hFFFF,
  parameter logic [31:0] TIM_RST   = 32'h0000_1485
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  reg_sel_t             sel,
  input  logic [31:0]          wdata,
  input  logic                 data_load,
  input  logic [PAGE_BITS-1:0] data_next,
  output logic [15:0]          ctrl_q,
  output logic [15:0]          ben_q,
  output logic [15:0]          stat_q,
  output logic [31:0]          tim_q,
  output logic [PAGE_BITS-1:0] data_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ben_q  <= BEN_RST;
      stat_q <= '0;
      tim_q  <= TIM_RST;
    end else if (wr) begin
      if (sel.ctrl) begin
        ctrl_q <= wdata[15:0] & CTRL_MASK;
        stat_q <= stat_q | 16'h0001;
      end
      if (sel.ben)  ben_q  <= wdata[15:0];
      if (sel.stat) stat_q <= stat_q & ~wdata[15:0];
      if (sel.tim)  tim_q  <= wdata;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q[32*k +: 32] <= '0;
      end else if (wr && sel.data[k]) begin
        data_q[32*k +: 32] <= wdata;
      end else if (data_load) begin
        data_q[32*k +: 32] <= data_next[32*k +: 32];
      end
    end
  end

endmodule

// File: rtl/pgmem_ctrl.sv
module pgmem_ctrl
  import pgmem_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PAGES     = 512,
  parameter logic [15:0] CTRL_MASK = 16'h39FF,
  parameter int unsigned WR_BIT    = 11,
  parameter int unsigned RD_BIT    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [1:0]        bus_err
);

  localparam int unsigned PAGE_AW = $clog2(PAGES);

  reg_sel_t             sel;
  acc_err_e             err;
  logic [15:0]          ctrl_q, ben_q, stat_q;
  logic [31:0]          tim_q;
  logic [PAGE_BITS-1:0] data_q, data_next;
  logic [PAGE_BITS-1:0] page_old, page_new, page_src;
  logic [PAGE_AW-1:0]   xfer_page;

  // Named internal events
  logic ctrl_fire, stat_wr, xfer_wr, xfer_rd;

  pgmem_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid (bus_valid),
    .addr  (bus_addr),
    .size  (bus_size),
    .sel   (sel),
    .err   (err)
  );

  assign ctrl_fire = bus_write & sel.ctrl;
  assign stat_wr   = bus_write & sel.stat;
  assign xfer_page = bus_wdata[PAGE_AW-1:0];
  assign xfer_wr   = ctrl_fire & bus_wdata[WR_BIT];
  assign xfer_rd   = ctrl_fire & bus_wdata[RD_BIT];

  pgmem_array #(.PAGES(PAGES), .PAGE_AW(PAGE_AW)) u_arr (
    .clk    (clk),
    .wr_en  (xfer_wr),
    .page   (xfer_page),
    .wr_val (page_new),
    .rd_val (page_old)
  );

  // Write first, then read sees the merged page.
  assign page_new  = byte_merge(page_old, write_image(data_q[31:0], data_q[63:32]), ben_q);
  assign page_src  = xfer_wr ? page_new : page_old;
  assign data_next = byte_merge(data_q, page_src, ben_q);

  pgmem_regfile #(.CTRL_MASK(CTRL_MASK)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_write),
    .sel       (sel),
    .wdata     (bus_wdata),
    .data_load (xfer_rd),
    .data_next (data_next),
    .ctrl_q    (ctrl_q),
    .ben_q     (ben_q),
    .stat_q    (stat_q),
    .tim_q     (tim_q),
    .data_q    (data_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (!bus_write) begin
      if (sel.ctrl) bus_rdata = {16'h0, ctrl_q};
      if (sel.ben)  bus_rdata = {16'h0, ben_q};
      if (sel.stat) bus_rdata = {16'h0, stat_q};
      if (sel.tim)  bus_rdata = tim_q;
      for (int k = 0; k < 4; k++) begin
        if (sel.data[k]) bus_rdata = data_q[32*k +: 32];
      end
    end
  end

  assign bus_err = err;

endmodule

module pgmem_ctrl_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_valid,
  input logic [1:0]   bus_size,
  input logic [31:0]  bus_wdata,
  input logic [1:0]   bus_err,
  input logic         ctrl_fire,
  input logic         stat_wr,
  input logic         xfer_rd,
  input logic [15:0]  ctrl_q,
  input logic [15:0]  ben_q,
  input logic [15:0]  stat_q,
  input logic [31:0]  tim_q,
  input logic [127:0] data_q
);

  assert_refused_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_err != 2'd0) |=> ($stable(ctrl_q) && $stable(ben_q) &&
      $stable(stat_q) && $stable(tim_q) && $stable(data_q)));

  assert_size_before_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_size != 2'd1 && bus_size != 2'd2) |-> bus_err == 2'd1);

  assert_ctrl_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_fire |=> ctrl_q == ($past(bus_wdata[15:0]) & 16'h39FF));

  assert_done_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_fire |=> stat_q[0]);

  assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && bus_wdata[0]) |=> !stat_q[0]);

  assert_no_enable_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_rd && ben_q == 16'h0) |=> $stable(data_q));

endmodule

bind pgmem_ctrl pgmem_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_size  (bus_size),
  .bus_wdata (bus_wdata),
  .bus_err   (bus_err),
  .ctrl_fire (ctrl_fire),
  .stat_wr   (stat_wr),
  .xfer_rd   (xfer_rd),
  .ctrl_q    (ctrl_q),
  .ben_q     (ben_q),
  .stat_q    (stat_q),
  .tim_q     (tim_q),
  .data_q    (data_q)
);

// File: tb/pgmem_ctrl_tb.sv
`timescale 1ns/1ps
module pgmem_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  bus_err;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pgmem_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  // Bench model
  logic [127:0] m_mem [512];
  logic [15:0]  m_ctrl, m_ben, m_stat;
  logic [31:0]  m_tim;
  logic [31:0]  m_data [4];
  int unsigned  pool [8] = '{0, 1, 2, 255, 256, 509, 510, 511};

  function automatic logic [1:0] exp_err(input logic [7:0] a, input logic [1:0] sz);
    if (sz != 2'd1 && sz != 2'd2) return 2'd1;
    case (a)
      8'h00, 8'h04, 8'h08: return (sz == 2'd1) ? 2'd0 : 2'd3;
      8'h0C, 8'h80, 8'h84, 8'h88, 8'h8C: return (sz == 2'd2) ? 2'd0 : 2'd3;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return {16'h0, m_ctrl};
      8'h04: return {16'h0, m_ben};
      8'h08: return {16'h0, m_stat};
      8'h0C: return m_tim;
      8'h80: return m_data[0];
      8'h84: return m_data[1];
      8'h88: return m_data[2];
      8'h8C: return m_data[3];
      default: return 32'h0;
    endcase
  endfunction

  // Byte b of the page image for a page write
  function automatic logic [7:0] img_byte(input int b);
    if (b < 4)  return m_data[0][8*b +: 8];
    if (b >= 8 && b < 12) return m_data[1][8*(b-8) +: 8];
    return 8'h00;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] wd);
    int unsigned p;
    case (a)
      8'h00: begin
        m_ctrl = wd[15:0] & 16'h39FF;
        p = wd[8:0];
        if (wd[11]) begin
          for (int b = 0; b < 16; b++)
            if (m_ben[b]) m_mem[p][8*b +: 8] = img_byte(b);
        end
        if (wd[12]) begin
          for (int b = 0; b < 16; b++)
            if (m_ben[b]) m_data[b/4][8*(b%4) +: 8] = m_mem[p][8*b +: 8];
        end
        m_stat = m_stat | 16'h1;
      end
      8'h04: m_ben  = wd[15:0];
      8'h08: m_stat = m_stat & ~wd[15:0];
      8'h0C: m_tim  = wd;
      8'h80: m_data[0] = wd;
      8'h84: m_data[1] = wd;
      8'h88: m_data[2] = wd;
      8'h8C: m_data[3] = wd;
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output logic [1:0] er);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_size = sz; bus_wdata = wd;
    #1;
    rd = bus_rdata; er = bus_err;
    @(posedge clk);
    #0.5;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [1:0] sz, input logic [31:0] wd);
    logic [31:0] rd; logic [1:0] er;
    bus(1'b1, a, sz, wd, rd, er);
    chk({tag, " err"}, 32'(er), 32'(exp_err(a, sz)));
    if (exp_err(a, sz) == 2'd0) model_write(a, wd);
  endtask

  task automatic rdc(input string tag, input logic [7:0] a, input logic [1:0] sz);
    logic [31:0] rd; logic [1:0] er;
    bus(1'b0, a, sz, 32'h0, rd, er);
    chk({tag, " err"}, 32'(er), 32'(exp_err(a, sz)));
    chk({tag, " data"}, rd, (exp_err(a, sz) == 2'd0) ? exp_read(a) : 32'h0);
  endtask

  task automatic read_data(input string tag);
    rdc(tag, 8'h80, 2'd2); rdc(tag, 8'h84, 2'd2);
    rdc(tag, 8'h88, 2'd2); rdc(tag, 8'h8C, 2'd2);
  endtask

  task automatic fill_data(input logic [31:0] a0, a1, a2, a3);
    wr("R9", 8'h80, 2'd2, a0); wr("R9", 8'h84, 2'd2, a1);
    wr("R9", 8'h88, 2'd2, a2); wr("R9", 8'h8C, 2'd2, a3);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL R0 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h80, 8'h84, 8'h88, 8'h8C};
    void'($urandom(32'd20240611));
    m_ctrl = 0; m_ben = 16'hFFFF; m_stat = 0; m_tim = 32'h0000_1485;
    for (int k = 0; k < 4; k++) m_data[k] = 0;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;

    // R1: reset values
    rdc("R1 ctrl", 8'h00, 2'd1); rdc("R1 ben", 8'h04, 2'd1);
    rdc("R1 stat", 8'h08, 2'd1); rdc("R1 timing", 8'h0C, 2'd2);
    read_data("R1 data");

    // R9 / R2: free writes and zero upper half on 16-bit reads
    wr("R9 ben", 8'h04, 2'd1, 32'hABCD_1234); rdc("R2 upper zero", 8'h04, 2'd1);
    wr("R9 timing", 8'h0C, 2'd2, 32'hDEAD_BEEF); rdc("R9 timing", 8'h0C, 2'd2);

    // R3: error priority and refused accesses
    wr("R3 bad size unmapped", 8'h40, 2'd0, 32'h1);
    wr("R3 bad size mapped", 8'h00, 2'd3, 32'h1FFF);
    wr("R3 unmapped", 8'h10, 2'd2, 32'h5);
    wr("R3 width ben", 8'h04, 2'd2, 32'h0);
    wr("R3 width data", 8'h80, 2'd1, 32'h7777);
    rdc("R3 read width", 8'h0C, 2'd1);
    rdc("R3 read unmapped", 8'h90, 2'd2);
    rdc("R3 ben kept", 8'h04, 2'd1);
    rdc("R3 stat kept", 8'h08, 2'd1);
    read_data("R3 data kept");

    // Initialise the page pool with full enable
    wr("R9 ben", 8'h04, 2'd1, 32'hFFFF);
    foreach (pool[i]) begin
      fill_data($urandom, $urandom, $urandom, $urandom);
      wr("R5 init", 8'h00, 2'd1, 32'h0800 | pool[i]);
    end

    // R5 + R6 + R10: write page 256, read it back in the next cycle
    fill_data(32'h0403_0201, 32'h0C0B_0A09, 32'hFFFF_FFFF, 32'hEEEE_EEEE);
    wr("R5", 8'h00, 2'd1, 32'h0800 | 256);
    fill_data(0, 0, 0, 0);
    wr("R6", 8'h00, 2'd1, 32'h1000 | 256);
    rdc("R10 immediate data0", 8'h80, 2'd2);
    read_data("R6 page256");

    // R5/R6 partial masks
    wr("R5", 8'h04, 2'd1, 32'h0F0F);
    fill_data(32'hA1A2_A3A4, 32'hB1B2_B3B4, 32'hC1C2_C3C4, 32'hD1D2_D3D4);
    wr("R5 partial", 8'h00, 2'd1, 32'h0800 | 255);
    wr("R6", 8'h04, 2'd1, 32'h3C5A);
    wr("R6 partial", 8'h00, 2'd1, 32'h1000 | 255);
    read_data("R6 partial");

    // R6: zero enable leaves data alone
    wr("R6", 8'h04, 2'd1, 32'h0000);
    wr("R6 no enable", 8'h00, 2'd1, 32'h1000 | 2);
    read_data("R6 no enable");

    // R7: both bits at once
    wr("R7", 8'h04, 2'd1, 32'hFFFF);
    fill_data(32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444);
    wr("R7 both", 8'h00, 2'd1, 32'h1800 | 2);
    read_data("R7 both");

    // R4: all-ones control write (page 511, both transfers)
    wr("R4 mask", 8'h00, 2'd1, 32'hFFFF_FFFF);
    rdc("R4 ctrl", 8'h00, 2'd1);
    read_data("R4 page511");

    // R8: done flag set and write-1-to-clear
    rdc("R8 set", 8'h08, 2'd1);
    wr("R8", 8'h08, 2'd1, 32'h0000); rdc("R8 write0 keeps", 8'h08, 2'd1);
    wr("R8", 8'h08, 2'd1, 32'h0001); rdc("R8 cleared", 8'h08, 2'd1);
    wr("R8 no xfer", 8'h00, 2'd1, 32'h0005); rdc("R8 set again", 8'h08, 2'd1);

    // Random traffic
    for (int n = 0; n < 600; n++) begin
      int unsigned op = $urandom_range(0, 9);
      case (op)
        0: wr("R9 rnd data", addrs[4 + $urandom_range(0, 3)], 2'd2, $urandom);
        1: begin
          int unsigned sel = $urandom_range(0, 3);
          wr("R9 rnd ben", 8'h04, 2'd1, sel == 0 ? 32'hFFFF : sel == 1 ? 32'h0 : $urandom);
        end
        2, 3: begin
          logic [31:0] wd = ($urandom & 32'hFFFF_E600) | pool[$urandom_range(0, 7)];
          wd[11] = $urandom_range(0, 1);
          wd[12] = $urandom_range(0, 1);
          wr("R7 rnd ctrl", 8'h00, 2'd1, wd);
          rdc("R10 rnd next", addrs[4 + $urandom_range(0, 3)], 2'd2);
        end
        4: wr("R8 rnd stat", 8'h08, 2'd1, $urandom);
        5: wr("R9 rnd timing", 8'h0C, 2'd2, $urandom);
        6: wr("R3 rnd bad", 8'($urandom), 2'($urandom), $urandom);
        7: rdc("R3 rnd bad read", 8'($urandom), 2'($urandom));
        default: rdc("R2 rnd read", addrs[$urandom_range(0, 7)],
                     ($urandom_range(0, 7) < 3) ? 2'd1 : 2'd2);
      endcase
    end
    foreach (addrs[i]) rdc("R2 final", addrs[i], (i < 3) ? 2'd1 : 2'd2);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule